// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policies

The block is a direct-mapped data cache. It sits between a processor-side load/store port and a word-wide port to the next memory level. Read hits are served from local storage. A read miss fetches the whole four-word line from the next level and then answers from the cache. Each line holds a tag, a valid flag and a dirty flag. Before a line with the dirty flag set is overwritten by a different block, its four words are copied out.

Two static parameters set the write behaviour, and the four combinations are independent. `WRITE_BACK` chooses what a write hit does. It either marks the line dirty and keeps the new data local, or it passes the word straight through to the next level. `WRITE_ALLOC` chooses what a write miss does. It either fetches the line first and then writes into it, or it sends the single word to the next level and leaves the cache untouched.

Both ports use a valid/ready handshake. The processor keeps its request steady until `cpuReady` is high. The next level accepts or returns one word in each cycle where `memValid` and `memReady` are both high.

Top module: `wpCache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses, and `cpuReady` stays low while `cpuValid` is low.
- R2: A read hit returns the stored word in the same cycle the request is presented (`cpuReady` high with no wait cycle) and produces no next-level beats.
- R3: A read miss performs exactly four read beats at word offsets 0, 1, 2, 3 of the aligned line, in that order, then returns the requested word.
- R4: With write-back, a write hit produces no next-level beats, leaves the next level's copy unchanged, and a later read returns the new value.
- R5: When a miss replaces a valid dirty line, four write beats carrying the old line go to the old line's addresses, and all of them finish before the first read beat of the refill.
- R6: Replacing a clean line, including one just brought in by a refill, produces no write beats.
- R7: With write-through, a write hit sends exactly one write beat carrying the new word to its address, and also updates the cached copy.
- R8: With write-through, lines never become dirty, so evicting a line that was written produces no write beats.
- R9: With write-allocate, a write miss refills the line with four read beats and then writes into it. Under write-back this adds no write beat and leaves the line dirty. Under write-through one write beat follows the last read beat.
- R10: With write-no-allocate, a write miss produces exactly one write beat and no read beats, and the cache contents and tags stay unchanged.
- R11: `cpuReady` is never high without `cpuValid`, and once `memValid` is high without `memReady`, the next-level request stays asserted with the same address on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | DATA_W | Load data, valid while cpuReady is high |
| memValid | output | 1 | Next-level beat requested |
| memWrite | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | ADDR_W | Word address of the beat |
| memWdata | output | DATA_W | Write-beat data |
| memReady | input | 1 | Next level accepts or returns the beat this cycle |
| memRdata | input | DATA_W | Read-beat data, valid with memReady |

## Verification
The most delicate overlap is a write miss that lands on a slot holding a dirty line. In that one access, the victim copy-out, the refill and the allocating store all follow one another, and under write-through an extra forwarded beat comes after them. The bench provokes this by first dirtying a line and then storing to another tag with the same index. It runs this under all four policy combinations. It logs every next-level beat with its direction and address, then checks three things: the beat counts, that every write beat precedes every read beat, and the final contents of both the next-level memory and the cache.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU
  } wpcState_t;

  typedef struct packed {
    logic cpuWrWord;   // write processor data into addressed word
    logic setDirty;    // mark indexed line dirty
    logic fillWord;    // store returned beat into line word [beat]
    logic fillDone;    // install tag, set valid, clear dirty
    logic cleanLine;   // victim copied out: clear dirty
    logic addrVictim;  // next-level address from stored tag
    logic addrFill;    // next-level address from request tag
  } wpcStrobes_t;

endpackage

// File: rtl/wpcDatapath.sv
module wpcDatapath
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int WORDS      = 4,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuWdata,
  input  wpcStrobes_t              strobes,
  input  logic [$clog2(WORDS)-1:0] beat,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     hit,
  output logic                     victimDirty,
  output logic [DATA_W-1:0]        cpuRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [DATA_W-1:0] dataArr [LINES*WORDS];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  dirtyBits;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tagIn;
  logic [DATA_W-1:0] lineWord;

  assign off   = cpuAddr[OFF_W-1:0];
  assign idx   = cpuAddr[OFF_W +: IDX_W];
  assign tagIn = cpuAddr[ADDR_W-1 -: TAG_W];

  assign hit         = validBits[idx] && (tagArr[idx] == tagIn);
  assign victimDirty = validBits[idx] && dirtyBits[idx];
  assign cpuRdata    = dataArr[{idx, off}];
  assign lineWord    = dataArr[{idx, beat}];

  always_comb begin
    if (strobes.addrVictim)    memAddr = {tagArr[idx], idx, beat};
    else if (strobes.addrFill) memAddr = {tagIn, idx, beat};
    else                       memAddr = cpuAddr;
  end

  assign memWdata = strobes.addrVictim ? lineWord : cpuWdata;

  always_ff @(posedge clk) begin
    if (strobes.fillWord)  dataArr[{idx, beat}] <= memRdata;
    if (strobes.cpuWrWord) dataArr[{idx, off}]  <= cpuWdata;
    if (strobes.fillDone)  tagArr[idx]          <= tagIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else begin
      if (strobes.fillDone) begin
        validBits[idx] <= 1'b1;
        dirtyBits[idx] <= 1'b0;
      end
      if (strobes.cleanLine) dirtyBits[idx] <= 1'b0;
      if (strobes.setDirty)  dirtyBits[idx] <= 1'b1;
    end
  end

  // R8
  wt_never_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK == 1'b0) |-> (dirtyBits == '0));

  // R5
  fill_after_clean_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.fillWord |-> !victimDirty);

endmodule

// File: rtl/wpcControl.sv
module wpcControl
  import wpc_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpuValid,
  input  logic                     cpuWrite,
  input  logic                     hit,
  input  logic                     victimDirty,
  input  logic                     memReady,
  output logic                     cpuReady,
  output logic                     memValid,
  output logic                     memWrite,
  output wpcStrobes_t              strobes,
  output logic [$clog2(WORDS)-1:0] beat
);
  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  wpcState_t state, nextState;
  logic lastBeat;

  assign lastBeat = (beat == LAST_BEAT);

  always_comb begin
    nextState = state;
    cpuReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          if (hit) begin
            if (!cpuWrite) begin
              cpuReady = 1'b1;
            end else if (WRITE_BACK) begin
              cpuReady          = 1'b1;
              strobes.cpuWrWord = 1'b1;
              strobes.setDirty  = 1'b1;
            end else begin
              nextState = ST_WTHRU;
            end
          end else if (cpuWrite && !WRITE_ALLOC) begin
            nextState = ST_WTHRU;
          end else if (victimDirty) begin
            nextState = ST_EVICT;
          end else begin
            nextState = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        memValid           = 1'b1;
        memWrite           = 1'b1;
        strobes.addrVictim = 1'b1;
        if (memReady && lastBeat) begin
          strobes.cleanLine = 1'b1;
          nextState         = ST_FILL;
        end
      end
      ST_FILL: begin
        memValid         = 1'b1;
        strobes.addrFill = 1'b1;
        if (memReady) begin
          strobes.fillWord = 1'b1;
          if (lastBeat) begin
            strobes.fillDone = 1'b1;
            nextState        = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          cpuReady          = 1'b1;
          strobes.cpuWrWord = hit;
          nextState         = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= nextState;
      if (memValid && memReady && (state == ST_EVICT || state == ST_FILL))
        beat <= beat + OFF_W'(1);
    end
  end

  // R11
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuValid);

  // R10
  nohit_store_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && cpuWrite && !hit) |-> (memValid && memWrite && memReady));

  // R4
  wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK && cpuReady && cpuWrite && hit) |-> !memValid);

endmodule

// File: rtl/wpCache.sv
module wpCache
  import wpc_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int LINES       = 8,
  parameter int WORDS       = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int OFF_W = $clog2(WORDS);

  wpcStrobes_t      strobes;
  logic [OFF_W-1:0] beat;
  logic             hit;
  logic             victimDirty;

  wpcControl #(
    .WORDS(WORDS), .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .hit(hit), .victimDirty(victimDirty), .memReady(memReady),
    .cpuReady(cpuReady), .memValid(memValid), .memWrite(memWrite),
    .strobes(strobes), .beat(beat)
  );

  wpcDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
    .WRITE_BACK(WRITE_BACK)
  ) u_dp (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .strobes(strobes), .beat(beat), .memRdata(memRdata),
    .hit(hit), .victimDirty(victimDirty), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  // R11
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

endmodule

// File: tb/wpcHarness.sv
module wpcHarness #(
  parameter bit WB = 1'b1,
  parameter bit WA = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output int   errCnt,
  output int   chkCnt,
  output logic done
);
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LOGN = 256;

  logic          cpuValid, cpuWrite, cpuReady;
  logic [AW-1:0] cpuAddr;
  logic [DW-1:0] cpuWdata, cpuRdata;
  logic          memValid, memWrite, memReady;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  wpCache #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .WORDS(4),
            .WRITE_BACK(WB), .WRITE_ALLOC(WA)) u_dut (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata)
  );

  // next-level model: ready every other cycle, beat log
  logic [DW-1:0] mem [1 << AW];
  logic          tick;
  logic          logWr   [LOGN];
  logic [AW-1:0] logAddr [LOGN];
  int            logPtr;

  function automatic logic [DW-1:0] initVal(input logic [AW-1:0] a);
    return 32'hD000_0000 | DW'(a);
  endfunction

  assign memReady = memValid & tick;
  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (rst) begin
      tick   <= 1'b0;
      logPtr <= 0;
      for (int i = 0; i < (1 << AW); i++) mem[i] <= initVal(AW'(i));
    end else begin
      tick <= ~tick;
      if (memValid && memReady) begin
        if (memWrite) mem[memAddr] <= memWdata;
        logWr[logPtr % LOGN]   <= memWrite;
        logAddr[logPtr % LOGN] <= memAddr;
        logPtr <= logPtr + 1;
      end
    end
  end

  function automatic logic [AW-1:0] mk(input int tg, input int ix, input int of);
    return AW'((tg << 5) | (ix << 2) | of);
  endfunction

  function automatic int countBeats(input int p0, input int p1, input logic wr);
    int n = 0;
    for (int k = p0; k < p1; k++) if (logWr[k % LOGN] == wr) n++;
    return n;
  endfunction

  // 1 when no write beat follows a read beat in the window
  function automatic bit writesFirst(input int p0, input int p1);
    bit seenRd = 0;
    for (int k = p0; k < p1; k++) begin
      if (!logWr[k % LOGN]) seenRd = 1;
      else if (seenRd) return 0;
    end
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s (WB=%0d WA=%0d) actual=%h expected=%h", req, WB, WA, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int waits,
                          output int p0, output int p1);
    @(negedge clk);
    p0 = logPtr;
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    #1;
    waits = 0;
    while (!cpuReady && waits < 500) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuValid = 1'b0; cpuWrite = 1'b0;
    p1 = logPtr;
    chk(waits < 500, "R11 completion", DW'(waits), 0);
  endtask

  localparam logic [DW-1:0] XV = 32'h1111_AAAA;
  localparam logic [DW-1:0] YV = 32'h2222_BBBB;
  localparam logic [DW-1:0] ZV = 32'h3333_CCCC;

  task automatic sReset();
    @(negedge clk); #1;
    chk(cpuReady == 1'b0, "R1 idle ready low", DW'(cpuReady), 0);
  endtask

  task automatic sReadMiss();
    logic [DW-1:0] rd; int w, p0, p1; bit ordOk;
    logic [AW-1:0] a = mk(1, 0, 2);
    doAccess(0, a, '0, rd, w, p0, p1);
    chk(rd == initVal(a), "R1 first read data", rd, initVal(a));
    chk(countBeats(p0, p1, 0) == 4, "R3 read beats", DW'(countBeats(p0, p1, 0)), 4);
    chk(countBeats(p0, p1, 1) == 0, "R3 no write beats", DW'(countBeats(p0, p1, 1)), 0);
    ordOk = (p1 - p0 == 4);
    for (int k = 0; k < 4; k++)
      if (logAddr[(p0 + k) % LOGN] != mk(1, 0, k)) ordOk = 0;
    chk(ordOk, "R3 refill order", DW'(logAddr[p0 % LOGN]), DW'(mk(1, 0, 0)));
  endtask

  task automatic sReadHit();
    logic [DW-1:0] rd; int w, p0, p1;
    logic [AW-1:0] a = mk(1, 0, 2);
    doAccess(0, a, '0, rd, w, p0, p1);
    chk(rd == initVal(a), "R2 hit data", rd, initVal(a));
    chk(w == 0, "R2 zero wait", DW'(w), 0);
    chk(p1 == p0, "R2 no traffic", DW'(p1 - p0), 0);
  endtask

  task automatic sWriteHit();
    logic [DW-1:0] rd; int w, p0, p1;
    logic [AW-1:0] a = mk(1, 0, 2);
    doAccess(1, a, XV, rd, w, p0, p1);
    if (WB) begin
      chk(p1 == p0, "R4 write hit quiet", DW'(p1 - p0), 0);
      chk(mem[a] == initVal(a), "R4 next level unchanged", mem[a], initVal(a));
    end else begin
      chk(countBeats(p0, p1, 1) == 1 && p1 - p0 == 1, "R7 one write beat",
          DW'(p1 - p0), 1);
      chk(mem[a] == XV, "R7 next level updated", mem[a], XV);
    end
    doAccess(0, a, '0, rd, w, p0, p1);
    chk(rd == XV && p1 == p0, WB ? "R4 readback" : "R7 readback", rd, XV);
  endtask

  task automatic sVictim();
    logic [DW-1:0] rd; int w, p0, p1;
    logic [AW-1:0] a = mk(1, 0, 2);
    logic [AW-1:0] b = mk(2, 0, 1);
    doAccess(0, b, '0, rd, w, p0, p1);
    chk(rd == initVal(b), "R5 new line data", rd, initVal(b));
    chk(countBeats(p0, p1, 0) == 4, "R5 refill beats", DW'(countBeats(p0, p1, 0)), 4);
    if (WB) begin
      chk(countBeats(p0, p1, 1) == 4, "R5 victim beats", DW'(countBeats(p0, p1, 1)), 4);
      chk(writesFirst(p0, p1), "R5 victim before refill", 0, 1);
      chk(logAddr[p0 % LOGN] == mk(1, 0, 0), "R5 victim address",
          DW'(logAddr[p0 % LOGN]), DW'(mk(1, 0, 0)));
      chk(mem[a] == XV, "R5 victim data", mem[a], XV);
    end else begin
      chk(countBeats(p0, p1, 1) == 0, "R8 no copy-out", DW'(countBeats(p0, p1, 1)), 0);
    end
  endtask

  task automatic sClean();
    logic [DW-1:0] rd; int w, p0, p1;
    logic [AW-1:0] c = mk(3, 0, 0);
    doAccess(0, c, '0, rd, w, p0, p1);
    chk(countBeats(p0, p1, 1) == 0, "R6 clean victim", DW'(countBeats(p0, p1, 1)), 0);
    chk(rd == initVal(c), "R6 data", rd, initVal(c));
  endtask

  task automatic sWriteMiss();
    logic [DW-1:0] rd; int w, p0, p1;
    logic [AW-1:0] d = mk(4, 1, 3);
    doAccess(1, d, YV, rd, w, p0, p1);
    if (WA) begin
      chk(countBeats(p0, p1, 0) == 4, "R9 refill beats", DW'(countBeats(p0, p1, 0)), 4);
      if (WB) begin
        chk(countBeats(p0, p1, 1) == 0, "R9 wb no write", DW'(countBeats(p0, p1, 1)), 0);
        chk(mem[d] == initVal(d), "R9 wb next level old", mem[d], initVal(d));
      end else begin
        chk(countBeats(p0, p1, 1) == 1 && logWr[(p1 - 1) % LOGN],
            "R9 wt write after refill", DW'(countBeats(p0, p1, 1)), 1);
        chk(mem[d] == YV, "R9 wt next level", mem[d], YV);
      end
      doAccess(0, d, '0, rd, w, p0, p1);
      chk(rd == YV && p1 == p0, "R9 allocated hit", rd, YV);
    end else begin
      chk(p1 - p0 == 1 && countBeats(p0, p1, 1) == 1, "R10 single forward",
          DW'(p1 - p0), 1);
      chk(mem[d] == YV, "R10 next level", mem[d], YV);
      doAccess(0, d, '0, rd, w, p0, p1);
      chk(countBeats(p0, p1, 0) == 4 && rd == YV, "R10 not allocated", rd, YV);
    end
  endtask

  task automatic sDirtyWriteMiss();
    logic [DW-1:0] rd; int w, p0, p1; int expWr, expRd;
    logic [AW-1:0] d = mk(4, 1, 3);
    logic [AW-1:0] e = mk(5, 1, 0);
    expWr = WA ? (WB ? 4 : 1) : 1;
    expRd = WA ? 4 : 0;
    doAccess(1, e, ZV, rd, w, p0, p1);
    chk(countBeats(p0, p1, 1) == expWr, WA ? "R9 combined writes" : "R10 combined writes",
        DW'(countBeats(p0, p1, 1)), DW'(expWr));
    chk(countBeats(p0, p1, 0) == expRd, WA ? "R9 combined reads" : "R10 combined reads",
        DW'(countBeats(p0, p1, 0)), DW'(expRd));
    chk(mem[d] == YV, "R5 old line preserved", mem[d], YV);
    if (WB && WA) begin
      chk(writesFirst(p0, p1), "R5 copy-out first", 0, 1);
      chk(mem[e] == initVal(e), "R4 store kept local", mem[e], initVal(e));
    end else begin
      chk(mem[e] == ZV, "R10 store reached next level", mem[e], ZV);
    end
    if (WA) begin
      doAccess(0, e, '0, rd, w, p0, p1);
      chk(rd == ZV && p1 == p0, "R9 combined hit", rd, ZV);
    end else begin
      doAccess(0, d, '0, rd, w, p0, p1);
      chk(rd == YV && p1 == p0, "R10 cache unchanged", rd, YV);
    end
  endtask

  initial begin
    errCnt = 0; chkCnt = 0; done = 1'b0;
    cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    @(negedge rst);
    sReset();
    sReadMiss();
    sReadHit();
    sWriteHit();
    sVictim();
    sClean();
    sWriteMiss();
    sDirtyWriteMiss();
    done = 1'b1;
  end

endmodule

// File: tb/wpCache_tb.sv
module wpCache_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int   e0, e1, e2, e3, c0, c1, c2, c3;
  logic d0, d1, d2, d3;

  wpcHarness #(.WB(1'b1), .WA(1'b1)) u_dut      (.clk(clk), .rst(rst), .errCnt(e0), .chkCnt(c0), .done(d0));
  wpcHarness #(.WB(1'b0), .WA(1'b1)) u_dut_wtwa (.clk(clk), .rst(rst), .errCnt(e1), .chkCnt(c1), .done(d1));
  wpcHarness #(.WB(1'b1), .WA(1'b0)) u_dut_wbna (.clk(clk), .rst(rst), .errCnt(e2), .chkCnt(c2), .done(d2));
  wpcHarness #(.WB(1'b0), .WA(1'b0)) u_dut_wtna (.clk(clk), .rst(rst), .errCnt(e3), .chkCnt(c3), .done(d3));

  initial begin
    int cycles = 0;
    int errs, chks;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    while (!(d0 && d1 && d2 && d3) && cycles < 200000) begin
      @(posedge clk); cycles++;
    end
    errs = e0 + e1 + e2 + e3;
    chks = c0 + c1 + c2 + c3;
    if (!(d0 && d1 && d2 && d3)) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=timeout expected=all scenarios done");
    end
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule